// File: doc/BRIEF.md
# Memory-Mapped SPI Controller

This block is a full-duplex serial peripheral that can act as bus master or as bus slave. It moves 8-bit frames with the most significant bit first. On every frame it shifts one byte out and one byte in during the same clock periods. A small register bank on a simple request/write bus holds the control bits, the divider, the transmit byte and the received byte, and shows status flags.

As master, the block makes the serial clock from the system clock through a 6-bit divider. Writing the transmit register while idle starts a frame. The active-low select output goes low for the length of the frame and returns high by itself afterwards. As slave, the block takes the serial clock, the select and the inbound data from outside. It passes them through two-flop synchronisers and finds the clock edges in the system clock domain. It keeps exchanging bytes for as long as the select stays low, and it sends the last loaded transmit byte again when software has not written a new one. One shift engine serves both roles. Clock polarity and phase choose which edge launches data and which edge samples it.

Top module: `spi_mmr_ctrl`

## Requirements
- R1: In master mode a frame drives the transmit byte on mosi_o MSB first, and the byte sampled from miso_i lands in the receive register (offset 0x04, MSB first).
- R2: In master mode the serial clock period is 2*(DIV+1) system clock cycles. DIV is bits [5:0] of the divider register at offset 0x0C and reads 0 after reset.
- R3: In master mode ssn_o is low from the start of a frame until it ends and high otherwise. Each frame has exactly 16 serial clock transitions, and ssn_o is high again once the frame is done.
- R4: The control register at offset 0x10 holds bit0 = master, bit1 = CPOL and bit2 = CPHA. The idle serial clock level equals CPOL, and the leading edge is the transition away from CPOL. With CPHA=0 data is sampled on leading edges and launched on trailing edges, and the first bit is present before the first edge. With CPHA=1 data is launched on leading edges and sampled on trailing edges.
- R5: In master mode a write to the transmit register (offset 0x08) while idle starts a frame. Status bit0 (busy, status at offset 0x00) reads 1 during the frame and 0 afterwards. A transmit write while busy starts no further frame.
- R6: Status bit1 (receive full) sets when a byte lands in the receive register and clears when offset 0x04 is read. Status bit2 (overrun) sets when a byte lands while bit1 is still set, and clears when the status register is read.
- R7: In slave mode a falling ssn_i starts an exchange. Bytes keep being exchanged while ssn_i stays low, and each completed byte from mosi_i lands in the receive register while miso_o carries the transmit byte MSB first.
- R8: In slave mode miso_oe is 1 only while the synchronised select is low, and it returns to 0 within 4 system clocks of ssn_i rising. mst_oe is 1 in master mode and 0 in slave mode.
- R9: In slave mode, when no transmit write happens between bytes, the last loaded transmit byte is sent again.
- R10: Reads return data one cycle after the request. The receive register resets to 0x00, the transmit offset reads 0x00, and the status and control registers read 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the divider reference |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read request |
| sclk_o | output | 1 | Serial clock driven in master mode (CPOL when idle) |
| sclk_i | input | 1 | Serial clock from an external master |
| ssn_o | output | 1 | Active-low select driven in master mode |
| ssn_i | input | 1 | Active-low select from an external master |
| mosi_o | output | 1 | Outbound data in master mode |
| mosi_i | input | 1 | Inbound data in slave mode |
| miso_o | output | 1 | Outbound data in slave mode |
| miso_i | input | 1 | Inbound data in master mode |
| miso_oe | output | 1 | Output enable for miso_o (slave mode, select low) |
| mst_oe | output | 1 | Output enable for sclk_o, ssn_o and mosi_o (master mode) |

## Verification
A wrong bit count or a wrong shift direction in the engine shows at the ports within one frame. The received byte comes out rotated or bit-reversed, the bits seen on mosi_o or miso_o are displaced, or the frame no longer has exactly 16 clock transitions. A divider or sequencer that is off by one shows as a wrong lead-to-lead spacing of sclk_o, or as ssn_o rising early or staying low. Errors in the flag logic or the reload logic appear at the next status read, or on the second byte of a slave burst.

// File: rtl/spi_mmr_pkg.sv
package spi_mmr_pkg;

    localparam int FRAME_BITS = 8;
    localparam int DIVISOR_W  = 6;
    localparam int OFFSET_W   = 5;
    localparam int SYNC_DEPTH = 2;

    localparam logic [OFFSET_W-1:0] OFS_STAT = 5'h00;
    localparam logic [OFFSET_W-1:0] OFS_RX   = 5'h04;
    localparam logic [OFFSET_W-1:0] OFS_TX   = 5'h08;
    localparam logic [OFFSET_W-1:0] OFS_DIV  = 5'h0C;
    localparam logic [OFFSET_W-1:0] OFS_CTRL = 5'h10;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_TAIL
    } seq_state_t;

    typedef struct packed {
        logic [4:0] spare;
        logic       cpha;
        logic       cpol;
        logic       master;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] zero;
        logic       overrun;
        logic       rx_full;
        logic       busy;
    } stat_t;

    // Leading edge is the transition away from the idle level CPOL.
    function automatic logic pick_lead(input logic cpol, input logic rise, input logic fall);
        return cpol ? fall : rise;
    endfunction

    function automatic logic pick_trail(input logic cpol, input logic rise, input logic fall);
        return cpol ? rise : fall;
    endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int DIV_W = spi_mmr_pkg::DIVISOR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == div_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/spi_master_seq.sv
module spi_master_seq
    import spi_mmr_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    input  logic cpol_i,
    output logic run_o,
    output logic sclk_o,
    output logic ssn_o,
    output logic lead_o,
    output logic trail_o
);

    localparam int EDGES = 2 * FRAME_W;
    localparam int HC_W  = $clog2(EDGES);

    seq_state_t      st_q;
    logic [HC_W-1:0] hc_q;
    logic            ph_q;
    logic            ssn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            hc_q  <= '0;
            ph_q  <= 1'b0;
            ssn_q <= 1'b1;
        end else begin
            unique case (st_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        st_q  <= SEQ_RUN;
                        hc_q  <= '0;
                        ph_q  <= 1'b0;
                        ssn_q <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (tick_i) begin
                        ph_q <= ~ph_q;
                        hc_q <= hc_q + 1'b1;
                        if (hc_q == HC_W'(EDGES - 1)) begin
                            st_q <= SEQ_TAIL;
                        end
                    end
                end
                SEQ_TAIL: begin
                    if (tick_i) begin
                        st_q  <= SEQ_IDLE;
                        ssn_q <= 1'b1;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign run_o   = (st_q != SEQ_IDLE);
    assign lead_o  = tick_i && (st_q == SEQ_RUN) && !hc_q[0];
    assign trail_o = tick_i && (st_q == SEQ_RUN) && hc_q[0];
    assign sclk_o  = cpol_i ^ ph_q;
    assign ssn_o   = ssn_q;

    // R3
    sclk_framed_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ph_q) |-> !ssn_q);

    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_IDLE && !start_i) |=> ssn_q);

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
    parameter int SYNC_N = spi_mmr_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic ssn_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic ssn_o,
    output logic ssn_fall_o,
    output logic mosi_o
);

    logic [SYNC_N-1:0] sck_sy;
    logic [SYNC_N-1:0] ss_sy;
    logic [SYNC_N-1:0] mo_sy;
    logic              sck_d;
    logic              ss_d;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sy <= '0;
                    ss_sy  <= '1;
                    mo_sy  <= '0;
                end else begin
                    sck_sy <= sclk_i;
                    ss_sy  <= ssn_i;
                    mo_sy  <= mosi_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sy <= '0;
                    ss_sy  <= '1;
                    mo_sy  <= '0;
                end else begin
                    sck_sy <= {sck_sy[SYNC_N-2:0], sclk_i};
                    ss_sy  <= {ss_sy[SYNC_N-2:0], ssn_i};
                    mo_sy  <= {mo_sy[SYNC_N-2:0], mosi_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_sy[SYNC_N-1];
            ss_d  <= ss_sy[SYNC_N-1];
        end
    end

    assign sclk_rise_o = sck_sy[SYNC_N-1] & ~sck_d;
    assign sclk_fall_o = ~sck_sy[SYNC_N-1] & sck_d;
    assign ssn_o       = ss_sy[SYNC_N-1];
    assign ssn_fall_o  = ~ss_sy[SYNC_N-1] & ss_d;
    assign mosi_o      = mo_sy[SYNC_N-1];

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = spi_mmr_pkg::FRAME_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         clear_i,
    input  logic [W-1:0] tx_i,
    input  logic         cpha_i,
    input  logic         lead_i,
    input  logic         trail_i,
    input  logic         sdi_i,
    output logic         sdo_o,
    output logic         done_o,
    output logic [W-1:0] rx_o
);

    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     sh_q;
    logic [W-2:0]     rxs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             samp;
    logic             launch;

    assign samp   = cpha_i ? trail_i : lead_i;
    assign launch = cpha_i ? lead_i  : trail_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rxs_q  <= '0;
            cnt_q  <= '0;
            sdo_o  <= 1'b0;
            done_o <= 1'b0;
            rx_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                cnt_q <= '0;
                if (!cpha_i) begin
                    sdo_o <= tx_i[W-1];
                    sh_q  <= tx_i << 1;
                end else begin
                    sh_q  <= tx_i;
                end
            end else if (clear_i) begin
                cnt_q <= '0;
            end else begin
                if (samp) begin
                    rxs_q <= {rxs_q[W-3:0], sdi_i};
                    if (cnt_q == CNT_W'(W - 1)) begin
                        cnt_q  <= '0;
                        done_o <= 1'b1;
                        rx_o   <= {rxs_q, sdi_i};
                        sh_q   <= tx_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                if (launch) begin
                    sdo_o <= sh_q[W-1];
                    sh_q  <= sh_q << 1;
                end
            end
        end
    end

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(lead_i && trail_i));

endmodule

// File: rtl/spi_mmr_ctrl.sv
module spi_mmr_ctrl
    import spi_mmr_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int DIV_W   = DIVISOR_W,
    parameter int ADDR_W  = OFFSET_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [FRAME_W-1:0] bus_wdata,
    output logic [FRAME_W-1:0] bus_rdata,
    output logic               sclk_o,
    input  logic               sclk_i,
    output logic               ssn_o,
    input  logic               ssn_i,
    output logic               mosi_o,
    input  logic               mosi_i,
    output logic               miso_o,
    input  logic               miso_i,
    output logic               miso_oe,
    output logic               mst_oe
);

    ctrl_t              ctrl_q;
    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic               rx_full_q;
    logic               ovr_q;

    logic wr, rd, wr_tx, wr_div, wr_ctrl, rd_rx, rd_stat;
    assign wr      = bus_req && bus_we;
    assign rd      = bus_req && !bus_we;
    assign wr_tx   = wr && (bus_addr == ADDR_W'(OFS_TX));
    assign wr_div  = wr && (bus_addr == ADDR_W'(OFS_DIV));
    assign wr_ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign rd_rx   = rd && (bus_addr == ADDR_W'(OFS_RX));
    assign rd_stat = rd && (bus_addr == ADDR_W'(OFS_STAT));

    logic m_run, m_tick, m_lead, m_trail, m_sclk, m_ssn, m_start;
    logic s_rise, s_fall, s_ssn, s_ssn_fall, s_mosi, s_lead, s_trail;
    logic e_start, e_clear, e_lead, e_trail, e_sdi, e_sdo, e_done;
    logic [FRAME_W-1:0] e_rx;
    logic [FRAME_W-1:0] tx_load;

    assign m_start = wr_tx && ctrl_q.master && !m_run;
    assign tx_load = wr_tx ? bus_wdata : tx_q;

    spi_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (m_run),
        .div_i  (div_q),
        .tick_o (m_tick)
    );

    spi_master_seq #(.FRAME_W(FRAME_W)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (m_start),
        .tick_i  (m_tick),
        .cpol_i  (ctrl_q.cpol),
        .run_o   (m_run),
        .sclk_o  (m_sclk),
        .ssn_o   (m_ssn),
        .lead_o  (m_lead),
        .trail_o (m_trail)
    );

    spi_slave_front #(.SYNC_N(SYNC_DEPTH)) front_i (
        .clk         (clk),
        .rst         (rst),
        .sclk_i      (sclk_i),
        .ssn_i       (ssn_i),
        .mosi_i      (mosi_i),
        .sclk_rise_o (s_rise),
        .sclk_fall_o (s_fall),
        .ssn_o       (s_ssn),
        .ssn_fall_o  (s_ssn_fall),
        .mosi_o      (s_mosi)
    );

    assign s_lead  = pick_lead(ctrl_q.cpol, s_rise, s_fall) && !s_ssn;
    assign s_trail = pick_trail(ctrl_q.cpol, s_rise, s_fall) && !s_ssn;

    assign e_start = ctrl_q.master ? m_start : s_ssn_fall;
    assign e_clear = ctrl_q.master ? 1'b0    : s_ssn;
    assign e_lead  = ctrl_q.master ? m_lead  : s_lead;
    assign e_trail = ctrl_q.master ? m_trail : s_trail;
    assign e_sdi   = ctrl_q.master ? miso_i  : s_mosi;

    spi_shifter #(.W(FRAME_W)) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (e_start),
        .clear_i (e_clear),
        .tx_i    (tx_load),
        .cpha_i  (ctrl_q.cpha),
        .lead_i  (e_lead),
        .trail_i (e_trail),
        .sdi_i   (e_sdi),
        .sdo_o   (e_sdo),
        .done_o  (e_done),
        .rx_o    (e_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            tx_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            if (wr_tx)   tx_q   <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q      <= '0;
            rx_full_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (e_done) begin
                rx_q      <= e_rx;
                rx_full_q <= 1'b1;
                if (rx_full_q && !rd_rx) begin
                    ovr_q <= 1'b1;
                end else if (rd_stat) begin
                    ovr_q <= 1'b0;
                end
            end else begin
                if (rd_rx)   rx_full_q <= 1'b0;
                if (rd_stat) ovr_q     <= 1'b0;
            end
        end
    end

    stat_t stat_w;
    assign stat_w = '{zero: '0, overrun: ovr_q, rx_full: rx_full_q, busy: m_run};

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd) begin
            unique case (bus_addr)
                ADDR_W'(OFS_STAT): bus_rdata <= FRAME_W'(stat_w);
                ADDR_W'(OFS_RX):   bus_rdata <= rx_q;
                ADDR_W'(OFS_DIV):  bus_rdata <= FRAME_W'(div_q);
                ADDR_W'(OFS_CTRL): bus_rdata <= FRAME_W'(ctrl_q);
                default:           bus_rdata <= '0;
            endcase
        end
    end

    assign sclk_o  = m_sclk;
    assign ssn_o   = m_ssn;
    assign mosi_o  = e_sdo;
    assign miso_o  = e_sdo;
    assign mst_oe  = ctrl_q.master;
    assign miso_oe = !ctrl_q.master && !s_ssn;

    // R6
    rx_full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full_q) |-> $past(rd_rx));

    // R8
    miso_drive_chk: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> (ssn_o && !m_run));

endmodule

// File: tb/spi_mmr_ctrl_tb.sv
module spi_mmr_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    // {cpol, cpha, div[5:0], tx[7:0], slave byte[7:0]}
    localparam logic [23:0] MVEC [6] = '{
        {1'b0, 1'b0, 6'd0,  8'hA5, 8'h3C},
        {1'b0, 1'b1, 6'd1,  8'h5A, 8'hC3},
        {1'b1, 1'b0, 6'd2,  8'h81, 8'h7E},
        {1'b1, 1'b1, 6'd3,  8'hFF, 8'h00},
        {1'b0, 1'b0, 6'd63, 8'h01, 8'h80},
        {1'b1, 1'b1, 6'd0,  8'h6B, 8'hD2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk_o, ssn_o, mosi_o, miso_o, miso_oe, mst_oe;
    logic       sclk_i = 1'b0;
    logic       ssn_i = 1'b1;
    logic       mosi_i = 1'b0;
    logic       miso_i = 1'b0;

    int checks = 0;
    int errors = 0;

    spi_mmr_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk_o    (sclk_o),
        .sclk_i    (sclk_i),
        .ssn_o     (ssn_o),
        .ssn_i     (ssn_i),
        .mosi_o    (mosi_o),
        .mosi_i    (mosi_i),
        .miso_o    (miso_o),
        .miso_i    (miso_i),
        .miso_oe   (miso_oe),
        .mst_oe    (mst_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_frame_end();
        bit seen_low = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!ssn_o) seen_low = 1'b1;
            if (seen_low && ssn_o) break;
        end
    endtask

    // Master frame with a bench slave model on miso_i.
    task automatic run_master(input logic [23:0] v);
        logic       cpol, cpha;
        logic [5:0] dv;
        logic [7:0] tx, mb, got_mosi, rdv;
        logic       prev;
        int         edges, leads, trails, t1, t2, bad_frame;
        bit         seen_low;
        cpol = v[23]; cpha = v[22]; dv = v[21:16]; tx = v[15:8]; mb = v[7:0];
        bus_wr(5'h10, {5'b0, cpha, cpol, 1'b1});
        bus_wr(5'h0C, {2'b0, dv});
        wait_cyc(3);
        check("R4 idle sclk level", sclk_o, cpol);
        miso_i = cpha ? 1'b0 : mb[7];
        prev = sclk_o;
        edges = 0; leads = 0; trails = 0; t1 = 0; t2 = 0; bad_frame = 0;
        got_mosi = '0; seen_low = 1'b0;
        bus_wr(5'h08, tx);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!ssn_o) seen_low = 1'b1;
            if (sclk_o !== prev) begin
                edges++;
                if (ssn_o) bad_frame++;
                if (sclk_o != cpol) begin
                    if (leads == 0) t1 = i;
                    if (leads == 1) t2 = i;
                    if (!cpha) got_mosi = {got_mosi[6:0], mosi_o};
                    else miso_i = mb[7 - leads];
                    leads++;
                end else begin
                    if (cpha) got_mosi = {got_mosi[6:0], mosi_o};
                    else if (trails < 7) miso_i = mb[6 - trails];
                    trails++;
                end
                prev = sclk_o;
            end
            if (seen_low && ssn_o) break;
        end
        check("R1 mosi byte", got_mosi, tx);
        check("R2 sclk period", t2 - t1, 2 * (dv + 1));
        check("R3 transition count", edges, 16);
        check("R3 select low over frame", bad_frame, 0);
        check("R3 select released", ssn_o, 1'b1);
        bus_rd(5'h04, rdv);
        check("R1 rx byte", rdv, mb);
    endtask

    // Bench master driving the slave pins.
    task automatic run_slave(input logic cpol, input logic cpha, input logic [7:0] b0,
                             input logic [7:0] b1, output logic [7:0] g0, output logic [7:0] g1);
        logic [7:0] bytes [2];
        logic [7:0] got;
        bytes[0] = b0; bytes[1] = b1;
        @(negedge clk);
        ssn_i = 1'b0;
        wait_cyc(HALF);
        check("R8 miso_oe while selected", miso_oe, 1'b1);
        for (int k = 0; k < 2; k++) begin
            got = '0;
            for (int b = 7; b >= 0; b--) begin
                if (!cpha) begin
                    mosi_i = bytes[k][b];
                    wait_cyc(HALF);
                    sclk_i = ~cpol;
                    got = {got[6:0], miso_o};
                    wait_cyc(HALF);
                    sclk_i = cpol;
                end else begin
                    sclk_i = ~cpol;
                    mosi_i = bytes[k][b];
                    wait_cyc(HALF);
                    sclk_i = cpol;
                    got = {got[6:0], miso_o};
                    wait_cyc(HALF);
                end
            end
            if (k == 0) g0 = got; else g1 = got;
        end
        wait_cyc(HALF);
        ssn_i = 1'b1;
        wait_cyc(4);
        check("R8 miso_oe released", miso_oe, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rdv, g0, g1;
        int         moves;
        logic       prev;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);

        // Reset state
        check("R10 ssn_o after reset", ssn_o, 1'b1);
        check("R8 miso_oe after reset", miso_oe, 1'b0);
        check("R8 mst_oe after reset", mst_oe, 1'b0);
        bus_rd(5'h00, rdv); check("R10 status after reset", rdv, 8'h00);
        bus_rd(5'h04, rdv); check("R10 rx after reset", rdv, 8'h00);
        bus_rd(5'h0C, rdv); check("R2 divider after reset", rdv, 8'h00);
        bus_rd(5'h10, rdv); check("R10 ctrl after reset", rdv, 8'h00);
        bus_rd(5'h08, rdv); check("R10 tx reads zero", rdv, 8'h00);

        // Vector table walk: master frames
        for (int n = 0; n < 6; n++) begin
            run_master(MVEC[n]);
        end
        check("R8 mst_oe in master", mst_oe, 1'b1);
        bus_rd(5'h0C, rdv); check("R2 divider readback", rdv, 8'h00);

        // Busy and writes while busy
        miso_i = 1'b0;
        bus_wr(5'h10, 8'h01);
        bus_wr(5'h0C, 8'h03);
        bus_wr(5'h08, 8'h11);
        bus_rd(5'h00, rdv); check("R5 busy during frame", rdv[0], 1'b1);
        bus_wr(5'h08, 8'h22);
        wait_frame_end();
        prev = sclk_o; moves = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sclk_o !== prev || !ssn_o) moves++;
            prev = sclk_o;
        end
        check("R5 no frame from busy write", moves, 0);
        bus_rd(5'h00, rdv); check("R6 rx_full set, not busy", rdv, 8'h02);
        bus_rd(5'h04, rdv); check("R1 rx zero byte", rdv, 8'h00);
        bus_rd(5'h00, rdv); check("R6 rx_full cleared by read", rdv, 8'h00);

        // Overrun
        bus_wr(5'h08, 8'h33);
        wait_frame_end();
        bus_wr(5'h08, 8'h44);
        wait_frame_end();
        bus_rd(5'h00, rdv); check("R6 overrun set", rdv, 8'h06);
        bus_rd(5'h00, rdv); check("R6 overrun cleared by status read", rdv, 8'h02);
        bus_rd(5'h04, rdv);

        // Slave mode, CPOL=0 CPHA=0
        bus_wr(5'h10, 8'h00);
        sclk_i = 1'b0;
        wait_cyc(5);
        check("R8 mst_oe in slave", mst_oe, 1'b0);
        bus_wr(5'h08, 8'h96);
        run_slave(1'b0, 1'b0, 8'h3C, 8'hA1, g0, g1);
        check("R7 miso first byte", g0, 8'h96);
        check("R9 miso repeat byte", g1, 8'h96);
        bus_rd(5'h00, rdv); check("R7 two bytes landed", rdv, 8'h06);
        bus_rd(5'h04, rdv); check("R7 last rx byte", rdv, 8'hA1);

        // Slave mode, CPOL=1 CPHA=1
        bus_wr(5'h10, 8'h06);
        sclk_i = 1'b1;
        wait_cyc(5);
        check("R4 slave sclk_o idle at CPOL", sclk_o, 1'b1);
        bus_wr(5'h08, 8'h5B);
        run_slave(1'b1, 1'b1, 8'hE7, 8'h18, g0, g1);
        check("R7 miso first byte mode3", g0, 8'h5B);
        check("R9 miso repeat byte mode3", g1, 8'h5B);
        bus_rd(5'h00, rdv); check("R6 overrun in slave burst", rdv, 8'h06);
        bus_rd(5'h04, rdv); check("R7 last rx byte mode3", rdv, 8'h18);

        // Slave mode, CPOL=0 CPHA=1 with new byte
        bus_wr(5'h10, 8'h04);
        sclk_i = 1'b0;
        wait_cyc(5);
        bus_wr(5'h08, 8'hC4);
        run_slave(1'b0, 1'b1, 8'h69, 8'h0F, g0, g1);
        check("R7 miso first byte mode1", g0, 8'hC4);
        check("R9 miso repeat byte mode1", g1, 8'hC4);
        bus_rd(5'h04, rdv); check("R7 last rx byte mode1", rdv, 8'h0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule